// File: doc/BRIEF.md
# Interrupt Status, Acknowledge and Mask Unit

This block is the interrupt register pair of a network controller. Six event sources feed a status byte. Three of them are sticky and are set by one-cycle pulses: transmit done, transmit-empty and receive overrun. The other three are live levels: receive ready, buffer allocation done and a port/PHY event.

The low byte of the pair reads back as status. A write to the same byte is an acknowledge, and it clears the sticky bits written with a 1. The high byte is a read/write mask that selects which status bits may raise the interrupt line. Software reaches the two bytes with a single 16-bit access or with separate byte accesses, chosen by two byte enables.

The interrupt output is the OR of status AND mask, registered once, and it is active high. The top mask bit is reserved, and the block keeps it at 0 whatever value is written.

Top module: `evirq_regs`

## Requirements
- R1: After reset, the mask reads 0x00, status reads 0x04 (only transmit-empty, bit 2, set, with all level inputs low) and `irq_o` is 0.
- R2: `rd_data_o[7:0]` is status and `rd_data_o[15:8]` is the mask; status bits 7 and 6 always read 0.
- R3: A one-cycle pulse on `evt_tx_i`, `evt_txe_i` or `evt_ovrn_i` sets status bit 1, 2 or 4 respectively, visible from the clock edge that samples it and held afterwards.
- R4: A write with `wr_be_i[0]`=1 clears each sticky status bit (1, 2, 4) whose `wr_data_i` bit is 1; bits written 0 keep their value.
- R5: Status bits 0, 3 and 5 follow `lvl_rx_i`, `lvl_alloc_i` and `lvl_phy_i` combinationally, and acknowledge writes have no effect on them.
- R6: When a set pulse and an acknowledge of the same sticky bit fall in the same cycle, the bit ends up set.
- R7: A write with `wr_be_i[1]`=1 loads `wr_data_i[15:8]` into the mask, with mask bit 7 forced to 0.
- R8: A write with only `wr_be_i[0]` leaves the mask unchanged, and a write with only `wr_be_i[1]` acknowledges nothing, whatever the other data byte holds.
- R9: `irq_o` is one clock after the status and mask it is computed from: it is 1 when any status bit and its mask bit are both 1.
- R10: A status bit whose mask bit is 0 never raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register pair |
| wr_be_i | input | 2 | Byte enables: bit 0 acknowledge byte, bit 1 mask byte |
| wr_data_i | input | 16 | Write data: [7:0] acknowledge, [15:8] mask |
| rd_data_o | output | 16 | Read data: [7:0] status, [15:8] mask |
| evt_tx_i | input | 1 | Transmit-done pulse |
| evt_txe_i | input | 1 | Transmit-empty pulse |
| evt_ovrn_i | input | 1 | Receive-overrun pulse |
| lvl_rx_i | input | 1 | Receive-ready level |
| lvl_alloc_i | input | 1 | Allocation-done level |
| lvl_phy_i | input | 1 | Port/PHY event level |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Setting a sticky bit and acknowledging it can fall in the same cycle. The bench provokes this by driving a transmit pulse during a cycle whose acknowledge write has bit 1 set, and then judges the read-back status on the following half cycle, where bit 1 must still read 1. A second collision is between a word write that acknowledges and a mask load made by the same access. The bench checks that each byte acts only on its own register. It also checks the interrupt output against the status and mask of the previous cycle.

// File: rtl/evirq_pkg.sv
package evirq_pkg;

   localparam int NUM_SRC = 6;

   // status bit positions (software decodes these)
   localparam int B_RX    = 0;
   localparam int B_TX    = 1;
   localparam int B_TXE   = 2;
   localparam int B_ALLOC = 3;
   localparam int B_OVRN  = 4;
   localparam int B_PHY   = 5;

   typedef enum logic {
      SRC_LEVEL = 1'b0,
      SRC_STICKY = 1'b1
   } src_kind_e;

   function automatic src_kind_e kind_of(input int idx);
      if (idx == B_TX || idx == B_TXE || idx == B_OVRN) return SRC_STICKY;
      return SRC_LEVEL;
   endfunction

   function automatic logic reset_val_of(input int idx);
      return (idx == B_TXE) ? 1'b1 : 1'b0;
   endfunction

endpackage

// File: rtl/evirq_sticky_bit.sv
module evirq_sticky_bit #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= RST_VAL;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   // R3: a pulse sets the bit on the next edge
   a_r3_set_latches: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);

   // R4: an acknowledge without a competing set clears the bit
   a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q_o);

   // R6: set wins over acknowledge in the same cycle
   a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && set_i) |=> q_o);

   // R4: with neither set nor acknowledge the bit holds
   a_r4_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_i) |=> $stable(q_o));

endmodule

// File: rtl/evirq_mask_reg.sv
module evirq_mask_reg #(
   parameter int           BYTE_W = 8,
   parameter logic [7:0]   GUARD  = 8'h80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [BYTE_W-1:0] wdata_i,
   output logic [BYTE_W-1:0] q_o
);

   localparam logic [BYTE_W-1:0] KEEP = ~BYTE_W'(GUARD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= '0;
      else if (wr_i) q_o <= wdata_i & KEEP;
   end

   // R7: guarded bits never read back as 1
   a_r7_guard_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o & ~KEEP) == '0);

   // R8: mask changes only on a mask-byte write
   a_r8_mask_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(q_o));

endmodule

// File: rtl/evirq_irq_out.sv
module evirq_irq_out #(
   parameter int WIDTH      = 8,
   parameter bit REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] stat_i,
   input  logic [WIDTH-1:0] mask_i,
   output logic             irq_o
);

   logic hit;
   assign hit = |(stat_i & mask_i);

   if (REGISTERED) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= hit;
      end
      assign irq_o = irq_q;

      // R9: output follows the previous cycle's status and mask
      a_r9_irq_latency: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq_o == $past(|(stat_i & mask_i))));

      // R10: no enabled bit in the previous cycle means no request
      a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
         ((stat_i & mask_i) == '0) |=> !irq_o);
   end else begin : g_comb
      assign irq_o = hit;
   end

endmodule

// File: rtl/evirq_regs.sv
module evirq_regs
   import evirq_pkg::*;
#(
   parameter int         BYTE_W    = 8,
   parameter logic [7:0] MASK_GUARD = 8'h80,
   parameter bit         IRQ_REG   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en_i,
   input  logic [1:0]          wr_be_i,
   input  logic [2*BYTE_W-1:0] wr_data_i,
   output logic [2*BYTE_W-1:0] rd_data_o,
   input  logic                evt_tx_i,
   input  logic                evt_txe_i,
   input  logic                evt_ovrn_i,
   input  logic                lvl_rx_i,
   input  logic                lvl_alloc_i,
   input  logic                lvl_phy_i,
   output logic                irq_o
);

   localparam int PAIR_W = 2 * BYTE_W;

   if (BYTE_W < NUM_SRC) begin : g_bad_width
      $error("evirq_regs: BYTE_W must hold all sources");
   end
   if (BYTE_W != 8) begin : g_bad_byte
      $error("evirq_regs: byte lanes must be 8 bits");
   end

   logic [NUM_SRC-1:0] src_in;
   logic [BYTE_W-1:0]  status;
   logic [BYTE_W-1:0]  mask_q;
   logic [BYTE_W-1:0]  ack_byte;
   logic               ack_wr;
   logic               mask_wr;

   always_comb begin
      src_in         = '0;
      src_in[B_RX]    = lvl_rx_i;
      src_in[B_TX]    = evt_tx_i;
      src_in[B_TXE]   = evt_txe_i;
      src_in[B_ALLOC] = lvl_alloc_i;
      src_in[B_OVRN]  = evt_ovrn_i;
      src_in[B_PHY]   = lvl_phy_i;
   end

   assign ack_wr   = wr_en_i & wr_be_i[0];
   assign mask_wr  = wr_en_i & wr_be_i[1];
   assign ack_byte = wr_data_i[BYTE_W-1:0];

   for (genvar i = 0; i < BYTE_W; i++) begin : g_src
      if (i >= NUM_SRC) begin : g_rsvd
         assign status[i] = 1'b0;
      end else if (kind_of(i) == SRC_STICKY) begin : g_sticky
         evirq_sticky_bit #(.RST_VAL(reset_val_of(i))) u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (src_in[i]),
            .clr_i (ack_wr & ack_byte[i]),
            .q_o   (status[i])
         );
      end else begin : g_level
         assign status[i] = src_in[i];
      end
   end

   evirq_mask_reg #(.BYTE_W(BYTE_W), .GUARD(MASK_GUARD)) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (mask_wr),
      .wdata_i (wr_data_i[PAIR_W-1:BYTE_W]),
      .q_o     (mask_q)
   );

   evirq_irq_out #(.WIDTH(BYTE_W), .REGISTERED(IRQ_REG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_i (status),
      .mask_i (mask_q),
      .irq_o  (irq_o)
   );

   assign rd_data_o = {mask_q, status};

   // R2: reserved status bits read 0
   a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data_o[7:6] == 2'b00);

   // R5: level bits track their inputs regardless of acknowledge
   a_r5_level_track: assert property (@(posedge clk) disable iff (!rst_n)
      {rd_data_o[B_PHY], rd_data_o[B_ALLOC], rd_data_o[B_RX]} ==
      {lvl_phy_i, lvl_alloc_i, lvl_rx_i});

   // R8: a mask-only write leaves sticky status untouched absent pulses
   a_r8_no_ack_on_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !wr_be_i[0] && !evt_tx_i && !evt_txe_i && !evt_ovrn_i)
      |=> $stable({rd_data_o[B_OVRN], rd_data_o[B_TXE], rd_data_o[B_TX]}));

endmodule

// File: tb/evirq_regs_tb_top.sv
module evirq_regs_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_be = 2'b00;
   logic [15:0] wr_data = 16'h0;
   logic [15:0] rd_data;
   logic        ev_tx = 0, ev_txe = 0, ev_ovrn = 0;
   logic        lv_rx = 0, lv_alloc = 0, lv_phy = 0;
   logic        irq;

   int compared = 0;
   int mismatched = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   evirq_regs dut_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en), .wr_be_i(wr_be), .wr_data_i(wr_data),
      .rd_data_o(rd_data),
      .evt_tx_i(ev_tx), .evt_txe_i(ev_txe), .evt_ovrn_i(ev_ovrn),
      .lvl_rx_i(lv_rx), .lvl_alloc_i(lv_alloc), .lvl_phy_i(lv_phy),
      .irq_o(irq)
   );

   // vector: [40:38] pulses {ovrn,txe,tx}, [37:35] levels {phy,alloc,rx},
   // [34] write, [33:32] byte enables, [31:16] write data, [15:0] expected read
   function automatic logic [40:0] mk(logic [2:0] ev, logic [2:0] lv, logic wr,
                                      logic [1:0] be, logic [15:0] wd, logic [15:0] ex);
      return {ev, lv, wr, be, wd, ex};
   endfunction

   localparam logic [40:0] VEC [NV] = '{
      mk(3'b000, 3'b000, 1'b0, 2'b00, 16'h0000, 16'h0004), // R1 idle
      mk(3'b000, 3'b000, 1'b1, 2'b10, 16'hFF00, 16'h7F04), // R7 guard
      mk(3'b000, 3'b000, 1'b1, 2'b01, 16'h0004, 16'h7F00), // R4 ack txe
      mk(3'b001, 3'b000, 1'b0, 2'b00, 16'h0000, 16'h7F02), // R3 tx
      mk(3'b100, 3'b000, 1'b0, 2'b00, 16'h0000, 16'h7F12), // R3 ovrn
      mk(3'b000, 3'b001, 1'b0, 2'b00, 16'h0000, 16'h7F13), // R5 rx
      mk(3'b000, 3'b001, 1'b1, 2'b01, 16'h00FF, 16'h7F01), // R5 ack no effect
      mk(3'b000, 3'b110, 1'b0, 2'b00, 16'h0000, 16'h7F28), // R5 alloc phy
      mk(3'b001, 3'b000, 1'b1, 2'b01, 16'h0002, 16'h7F02), // R6 collision
      mk(3'b000, 3'b000, 1'b1, 2'b01, 16'hFFFF, 16'h7F00), // R8 ack only
      mk(3'b010, 3'b000, 1'b1, 2'b10, 16'h00FF, 16'h0004), // R8 mask only
      mk(3'b111, 3'b111, 1'b0, 2'b00, 16'h0000, 16'h003F), // R2 all set
      mk(3'b000, 3'b111, 1'b1, 2'b11, 16'h8116, 16'h0129), // R10 word write
      mk(3'b000, 3'b001, 1'b0, 2'b00, 16'h0000, 16'h0101), // R9 rx enabled
      mk(3'b000, 3'b000, 1'b0, 2'b00, 16'h0000, 16'h0100), // R9 drop
      mk(3'b000, 3'b010, 1'b0, 2'b00, 16'h0000, 16'h0108)  // R10 alloc masked
   };

   function automatic string tag_of(int i);
      case (i)
         0: return "R1";  1: return "R7";  2: return "R4";  3: return "R3";
         4: return "R3";  5: return "R5";  6: return "R5";  7: return "R5";
         8: return "R6";  9: return "R8"; 10: return "R8"; 11: return "R2";
        12: return "R10"; 13: return "R9"; 14: return "R9"; default: return "R10";
      endcase
   endfunction

   task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      logic [15:0] prev;
      logic [7:0]  lvl_bits;
      logic        irq_exp;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", rd_data, 16'h0004, "reset read");
      check("R1", {15'b0, irq}, 16'h0, "reset irq");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", rd_data, 16'h0004, "after release");

      prev = 16'h0004;
      for (int i = 0; i < NV; i++) begin
         {ev_ovrn, ev_txe, ev_tx} = VEC[i][40:38];
         {lv_phy, lv_alloc, lv_rx} = VEC[i][37:35];
         wr_en   = VEC[i][34];
         wr_be   = VEC[i][33:32];
         wr_data = VEC[i][31:16];
         lvl_bits = {2'b00, lv_phy, 1'b0, lv_alloc, 2'b00, lv_rx};
         irq_exp = |(((prev[7:0] & 8'h16) | lvl_bits) & prev[15:8]);
         @(negedge clk);
         check(tag_of(i), rd_data, VEC[i][15:0], $sformatf("vector %0d read", i));
         check("R9", {15'b0, irq}, {15'b0, irq_exp}, $sformatf("vector %0d irq", i));
         prev = VEC[i][15:0];
         {ev_ovrn, ev_txe, ev_tx} = 3'b000;
         wr_en = 1'b0;
      end

      // R1: reset in mid-run restores defaults
      lv_rx = 1'b0; lv_alloc = 1'b0; lv_phy = 1'b0;
      wr_en = 1'b1; wr_be = 2'b10; wr_data = 16'h0100; lv_rx = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
      @(negedge clk);
      check("R9", {15'b0, irq}, 16'h1, "irq raised before reset");
      rst_n = 1'b0;
      lv_rx = 1'b0;
      @(negedge clk);
      check("R1", rd_data, 16'h0004, "mid-run reset read");
      check("R1", {15'b0, irq}, 16'h0, "mid-run reset irq");
      rst_n = 1'b1;

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule